// File: doc/BRIEF.md
# Row-Streaming QR Handshake Scheduler

This block sequences the rows that feed a partial-systolic complex QR least-squares engine. The engine takes one row of the coefficient matrix A (COLS_N complex entries) and one row of the right-hand side B (COLS_P complex entries) at a time. The rotation arithmetic needs a fixed number of cycles per row, so the scheduler sets the pace. It raises `ready`, takes a row when `in_valid` is also high, and then holds `ready` low for one row period of c = 2·WORD_W + 15 cycles. The row goes out to the datapath on `dp_a`/`dp_b` together with a one-cycle `row_strobe` and a frame-relative `row_idx`.

When the elaboration constant `REG_LAMBDA` is nonzero, the block prepends a regularising block to every frame. It generates COLS_N rows by itself, and row k carries λ on the diagonal entry k of A and zeros in B. These rows are paced at the same row period, and `ready` stays low while they go out. After the last row of a frame the scheduler waits COLS_N row periods for the array to drain. It then pulses `valid_out` for one cycle and starts the next frame on the following cycle. A synchronous `restart` abandons the frame at any point. ROWS_M ≥ 2 and COLS_N ≥ 2 are enforced at elaboration. The defaults are ROWS_M = 4, COLS_N = 4, COLS_P = 1 and WORD_W = 16.

Top module: `qrs_row_sequencer`

## Requirements
- R1: A user row is taken only in a cycle where `in_valid`, `ready` are high and `restart`, `rst` are low. In that cycle `row_strobe` is 1, `row_injected` is 0, and `dp_a`/`dp_b` equal `in_a`/`in_b`. Whenever no injected row is being fed, `dp_a`/`dp_b` pass the inputs through.
- R2: After any row is fed in cycle T, `ready` is low until cycle T+c, with c = 2·WORD_W + 15. If further user rows are still due, `ready` is high from cycle T+c until a row is taken.
- R3: `row_idx` during a strobe equals the number of rows already fed in the current frame, counting from 0. Injected rows come first.
- R4: `valid_out` is high for exactly one cycle, c·COLS_N cycles after the last row of the frame. When every row is fed at the full rate, this is c·(total_rows + COLS_N − 1) cycles after the first row, which is c·(ROWS_M + COLS_N − 1) when λ = 0.
- R5: `rst` and `restart` are synchronous and active-high. In a cycle where either is high, `ready`, `row_strobe`, `row_injected` and `valid_out` are 0. In the next cycle a fresh frame begins with row index 0.
- R6: With λ ≠ 0, a frame opens with exactly COLS_N injected rows, spaced c cycles apart. The first one comes in the cycle a frame begins. `row_injected` is 1 for each of them, and `ready` stays low meanwhile.
- R7: Complex entry k occupies bits [2·WORD_W·k +: 2·WORD_W], with the real part in the low WORD_W bits. Injected row k sets entry k of `dp_a` to real λ, imaginary 0. All other A entries and all of `dp_b` are 0.
- R8: In the cycle after `valid_out`, a new frame begins. `ready` is high for λ = 0, or the first injected row is fed for λ ≠ 0.
- R9: When `restart` and `in_valid` are high together, no row is taken.
- R10: A frame holds ROWS_M rows when λ = 0 and ROWS_M + COLS_N rows otherwise. After the last one, `ready` stays low until `valid_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Abandon the current frame and clear all sequencing state |
| in_valid | input | 1 | Row on `in_a`/`in_b` is valid |
| in_a | input | COLS_N·2·WORD_W | Row of A, complex entries packed per R7 |
| in_b | input | COLS_P·2·WORD_W | Row of B, complex entries packed per R7 |
| ready | output | 1 | Scheduler will take a user row this cycle |
| row_strobe | output | 1 | A row is fed to the datapath this cycle |
| row_idx | output | clog2(ROWS_M+COLS_N) | Frame-relative index of the fed row |
| row_injected | output | 1 | The fed row is a generated regularisation row |
| dp_a | output | COLS_N·2·WORD_W | A row presented to the datapath |
| dp_b | output | COLS_P·2·WORD_W | B row presented to the datapath |
| valid_out | output | 1 | R and C of the frame are complete |

## Verification
A corrupted row counter shows up within one row period. It either makes `row_idx` disagree with the number of strobes seen in the frame, or it ends the frame one row early or late, which moves `valid_out` by a whole period of c cycles. A wrong period or drain count moves `ready` or `valid_out` off its exact cycle, and the per-cycle comparison against a timestamp model catches that at the first misplaced edge. A wrong phase shows up either as `ready` rising while rows are still being injected, or as injected rows appearing when λ is zero. Both are visible on the first row of the next frame.

// File: rtl/qrs_pkg.sv
`timescale 1ns/1ps
package qrs_pkg;

    typedef enum logic [1:0] {
        PH_INJECT = 2'd0,
        PH_USER   = 2'd1,
        PH_DRAIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic inject_fire;
        logic user_fire;
    } feed_t;

    function automatic int unsigned row_period(input int unsigned word_w);
        return 2 * word_w + 15;
    endfunction

    function automatic int unsigned width_of(input int unsigned count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/qrs_pacer.sv
`timescale 1ns/1ps
module qrs_pacer
    import qrs_pkg::*;
#(
    parameter int unsigned PERIOD = 47
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fire,
    output logic open
);
    localparam int unsigned CW = width_of(PERIOD);

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_q <= '0;
        end else if (fire) begin
            gap_q <= CW'(PERIOD - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign open = (gap_q == '0);
endmodule

// File: rtl/qrs_frame_ctl.sv
`timescale 1ns/1ps
module qrs_frame_ctl
    import qrs_pkg::*;
#(
    parameter int unsigned ROWS_M  = 4,
    parameter int unsigned COLS_N  = 4,
    parameter bit          HAS_REG = 1'b0,
    parameter int unsigned PERIOD  = 47,
    parameter int unsigned IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  feed_t            feed,
    output phase_e           phase,
    output logic [IDX_W-1:0] row_cnt,
    output logic             done
);
    localparam int unsigned TOTAL     = HAS_REG ? (ROWS_M + COLS_N) : ROWS_M;
    localparam int unsigned DRAIN_LEN = PERIOD * COLS_N;
    localparam int unsigned DW        = width_of(DRAIN_LEN);
    localparam phase_e      START     = HAS_REG ? PH_INJECT : PH_USER;
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] LAST_INJ = IDX_W'(COLS_N - 1);

    logic [DW-1:0] drain_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase   <= START;
            row_cnt <= '0;
            drain_q <= '0;
        end else begin
            unique case (phase)
                PH_INJECT: begin
                    if (feed.inject_fire) begin
                        row_cnt <= row_cnt + 1'b1;
                        if (row_cnt == LAST_INJ) begin
                            phase <= PH_USER;
                        end
                    end
                end
                PH_USER: begin
                    if (feed.user_fire) begin
                        if (row_cnt == LAST_ROW) begin
                            phase   <= PH_DRAIN;
                            drain_q <= DW'(DRAIN_LEN - 1);
                        end else begin
                            row_cnt <= row_cnt + 1'b1;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (drain_q == '0) begin
                        phase   <= START;
                        row_cnt <= '0;
                    end else begin
                        drain_q <= drain_q - 1'b1;
                    end
                end
                default: begin
                    phase   <= START;
                    row_cnt <= '0;
                end
            endcase
        end
    end

    assign done = (phase == PH_DRAIN) && (drain_q == '0);
endmodule

// File: rtl/qrs_row_mux.sv
`timescale 1ns/1ps
module qrs_row_mux
    import qrs_pkg::*;
#(
    parameter int unsigned COLS_N = 4,
    parameter int unsigned COLS_P = 1,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IDX_W  = 3,
    parameter logic [WORD_W-1:0] REG_LAMBDA = '0
) (
    input  logic                       inject,
    input  logic [IDX_W-1:0]           idx,
    input  logic [COLS_N*2*WORD_W-1:0] in_a,
    input  logic [COLS_P*2*WORD_W-1:0] in_b,
    output logic [COLS_N*2*WORD_W-1:0] dp_a,
    output logic [COLS_P*2*WORD_W-1:0] dp_b
);
    localparam int unsigned EW = 2 * WORD_W;
    localparam logic [EW-1:0] DIAG = {{WORD_W{1'b0}}, REG_LAMBDA};

    for (genvar k = 0; k < COLS_N; k++) begin : g_col
        logic on_diag;
        assign on_diag = (idx == IDX_W'(k));
        assign dp_a[k*EW +: EW] = inject ? (on_diag ? DIAG : '0)
                                         : in_a[k*EW +: EW];
    end

    assign dp_b = inject ? '0 : in_b;
endmodule

// File: rtl/qrs_row_sequencer.sv
`timescale 1ns/1ps
module qrs_row_sequencer
    import qrs_pkg::*;
#(
    parameter int unsigned ROWS_M = 4,
    parameter int unsigned COLS_N = 4,
    parameter int unsigned COLS_P = 1,
    parameter int unsigned WORD_W = 16,
    parameter logic [WORD_W-1:0] REG_LAMBDA = '0
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   restart,
    input  logic                                   in_valid,
    input  logic [COLS_N*2*WORD_W-1:0]             in_a,
    input  logic [COLS_P*2*WORD_W-1:0]             in_b,
    output logic                                   ready,
    output logic                                   row_strobe,
    output logic [width_of(ROWS_M+COLS_N)-1:0]     row_idx,
    output logic                                   row_injected,
    output logic [COLS_N*2*WORD_W-1:0]             dp_a,
    output logic [COLS_P*2*WORD_W-1:0]             dp_b,
    output logic                                   valid_out
);
    localparam int unsigned IDX_W   = width_of(ROWS_M + COLS_N);
    localparam int unsigned PERIOD  = row_period(WORD_W);
    localparam bit          HAS_REG = (REG_LAMBDA != '0);

    if (ROWS_M < 2 || COLS_N < 2 || COLS_P < 1) begin : g_dim_check
        $error("qrs_row_sequencer: ROWS_M and COLS_N must be at least 2, COLS_P at least 1");
    end

    logic             live;
    logic             slot_open;
    logic             frame_done;
    phase_e           phase;
    logic [IDX_W-1:0] row_cnt;
    feed_t            feed;

    assign live = !rst && !restart;

    assign ready            = live && (phase == PH_USER) && slot_open;
    assign feed.user_fire   = ready && in_valid;
    assign feed.inject_fire = live && (phase == PH_INJECT) && slot_open;

    qrs_pacer #(
        .PERIOD (PERIOD)
    ) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .fire  (feed.user_fire || feed.inject_fire),
        .open  (slot_open)
    );

    qrs_frame_ctl #(
        .ROWS_M  (ROWS_M),
        .COLS_N  (COLS_N),
        .HAS_REG (HAS_REG),
        .PERIOD  (PERIOD),
        .IDX_W   (IDX_W)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .feed    (feed),
        .phase   (phase),
        .row_cnt (row_cnt),
        .done    (frame_done)
    );

    qrs_row_mux #(
        .COLS_N     (COLS_N),
        .COLS_P     (COLS_P),
        .WORD_W     (WORD_W),
        .IDX_W      (IDX_W),
        .REG_LAMBDA (REG_LAMBDA)
    ) u_mux (
        .inject (feed.inject_fire),
        .idx    (row_cnt),
        .in_a   (in_a),
        .in_b   (in_b),
        .dp_a   (dp_a),
        .dp_b   (dp_b)
    );

    assign row_strobe   = feed.user_fire || feed.inject_fire;
    assign row_injected = feed.inject_fire;
    assign row_idx      = row_cnt;
    assign valid_out    = live && frame_done;
endmodule

// File: rtl/qrs_checker.sv
`timescale 1ns/1ps
module qrs_checker
    import qrs_pkg::*;
#(
    parameter int unsigned ROWS_M = 4,
    parameter int unsigned COLS_N = 4,
    parameter int unsigned COLS_P = 1,
    parameter int unsigned WORD_W = 16,
    parameter logic [WORD_W-1:0] REG_LAMBDA = '0
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               restart,
    input logic                               in_valid,
    input logic                               ready,
    input logic                               row_strobe,
    input logic [width_of(ROWS_M+COLS_N)-1:0] row_idx,
    input logic                               row_injected,
    input logic                               valid_out
);
    localparam int unsigned PERIOD    = row_period(WORD_W);
    localparam int unsigned DRAIN_LEN = PERIOD * COLS_N;
    localparam bit          HAS_REG   = (REG_LAMBDA != '0);
    localparam int unsigned TOTAL     = HAS_REG ? (ROWS_M + COLS_N) : ROWS_M;

    int unsigned since_q;
    logic        armed_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            since_q <= 0;
            armed_q <= 1'b0;
        end else begin
            if (row_strobe) begin
                since_q <= 1;
                armed_q <= 1'b1;
            end else if (since_q < DRAIN_LEN + 1) begin
                since_q <= since_q + 1;
            end
            if (valid_out) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_GATED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (row_strobe && !row_injected) |-> (ready && in_valid)); // R1
    AST_ROW_SPACING: assert property (@(posedge clk) disable iff (rst || restart)
        (row_strobe && armed_q) |-> (since_q >= PERIOD)); // R2
    AST_READY_SPACING: assert property (@(posedge clk) disable iff (rst || restart)
        (ready && armed_q) |-> (since_q >= PERIOD)); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        row_strobe |-> (row_idx < TOTAL)); // R3
    AST_DONE_DELAY: assert property (@(posedge clk) disable iff (rst || restart)
        valid_out |-> (armed_q && since_q == DRAIN_LEN)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> !valid_out); // R4
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
        restart |-> (!ready && !row_strobe && !valid_out && !row_injected)); // R5
    AST_INJECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        row_injected |-> (row_strobe && !ready)); // R6
    AST_NEXT_FRAME: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_out) && !restart) |-> (ready || row_injected)); // R8
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
        (restart && in_valid) |-> !row_strobe); // R9
endmodule

bind qrs_row_sequencer qrs_checker #(
    .ROWS_M     (ROWS_M),
    .COLS_N     (COLS_N),
    .COLS_P     (COLS_P),
    .WORD_W     (WORD_W),
    .REG_LAMBDA (REG_LAMBDA)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .in_valid     (in_valid),
    .ready        (ready),
    .row_strobe   (row_strobe),
    .row_idx      (row_idx),
    .row_injected (row_injected),
    .valid_out    (valid_out)
);

// File: tb/sim_qrs_row_sequencer.sv
`timescale 1ns/1ps
module sim_qrs_row_sequencer;
    localparam int PN   = 4;
    localparam int PW   = 16;
    localparam int C    = 2 * PW + 15;
    localparam int AW   = PN * 2 * PW;
    localparam int BW   = 2 * PW;
    localparam logic [PW-1:0] LAM1 = 16'h0123;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          restart = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_a = '0;
    logic [BW-1:0] in_b = '0;

    logic          rdy_o [2];
    logic          stb_o [2];
    logic [2:0]    idx_o [2];
    logic          inj_o [2];
    logic [AW-1:0] dpa_o [2];
    logic [BW-1:0] dpb_o [2];
    logic          vo_o  [2];

    qrs_row_sequencer #(
        .ROWS_M(4), .COLS_N(PN), .COLS_P(1), .WORD_W(PW), .REG_LAMBDA('0)
    ) u0 (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .ready(rdy_o[0]), .row_strobe(stb_o[0]),
        .row_idx(idx_o[0]), .row_injected(inj_o[0]), .dp_a(dpa_o[0]),
        .dp_b(dpb_o[0]), .valid_out(vo_o[0])
    );

    qrs_row_sequencer #(
        .ROWS_M(2), .COLS_N(PN), .COLS_P(1), .WORD_W(PW), .REG_LAMBDA(LAM1)
    ) u1 (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .ready(rdy_o[1]), .row_strobe(stb_o[1]),
        .row_idx(idx_o[1]), .row_injected(inj_o[1]), .dp_a(dpa_o[1]),
        .dp_b(dpb_o[1]), .valid_out(vo_o[1])
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int pm   [2] = '{4, 2};
    int lamv [2] = '{0, 'h0123};
    int ph   [2];
    int fed  [2];
    int wu   [2];
    int due  [2];
    int injn [2];
    int first[2];
    bit full [2];
    bit lastvo[2];

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic new_frame(input int d);
        ph[d]   = (lamv[d] != 0) ? 0 : 1;
        fed[d]  = 0;
        wu[d]   = cyc + 1;
        injn[d] = 0;
        full[d] = 1'b1;
    endtask

    task automatic model(input int d, input logic v, input logic rs, input logic r);
        int total;
        bit e_rdy, e_inj, e_stb, e_vo;
        logic [AW-1:0] ea;
        logic [BW-1:0] eb;
        string rtag;
        total = (lamv[d] != 0) ? pm[d] + PN : pm[d];
        e_rdy = 0; e_inj = 0; e_stb = 0; e_vo = 0;
        if (!(r || rs)) begin
            e_inj = (ph[d] == 0) && (cyc >= wu[d]);
            e_rdy = (ph[d] == 1) && (cyc >= wu[d]);
            e_stb = e_inj || (e_rdy && v);
            e_vo  = (ph[d] == 2) && (cyc == due[d]);
        end
        ea = in_a;
        eb = in_b;
        if (e_inj) begin
            ea = '0;
            ea[fed[d]*2*PW +: PW] = lamv[d][PW-1:0];
            eb = '0;
        end
        if (r || rs)           rtag = "R5";
        else if (lastvo[d])    rtag = "R8";
        else if (ph[d] == 2)   rtag = "R10";
        else                   rtag = "R2";
        chk($sformatf("%s ready u%0d", rtag, d), rdy_o[d], e_rdy);
        chk($sformatf("%s strobe u%0d", (rs && v) ? "R9" : "R1", d), stb_o[d], e_stb);
        chk($sformatf("R6 injected u%0d", d), inj_o[d], e_inj);
        if (e_stb) chk($sformatf("R3 row_idx u%0d", d), idx_o[d], fed[d]);
        chk($sformatf("%s dp_a u%0d", e_inj ? "R7" : "R1", d), dpa_o[d], ea);
        chk($sformatf("%s dp_b u%0d", e_inj ? "R7" : "R1", d), dpb_o[d], eb);
        chk($sformatf("R4 valid_out u%0d", d), vo_o[d], e_vo);
        lastvo[d] = e_vo;
        if (r || rs) begin
            new_frame(d);
            lastvo[d] = 1'b0;
        end else begin
            if (e_stb) begin
                if (fed[d] == 0) first[d] = cyc;
                else if (cyc != wu[d]) full[d] = 1'b0;
                if (e_inj) injn[d]++;
                fed[d]++;
                wu[d] = cyc + C;
                if (ph[d] == 0 && fed[d] == PN) ph[d] = 1;
                else if (ph[d] == 1 && fed[d] == total) begin
                    ph[d]  = 2;
                    due[d] = cyc + C * PN;
                end
            end
            if (e_vo) begin
                if (lamv[d] != 0) chk($sformatf("R6 injected rows per frame u%0d", d), injn[d], PN);
                if (full[d]) chk($sformatf("R4 first-row to valid_out u%0d", d),
                                 cyc - first[d], C * (total + PN - 1));
                new_frame(d);
            end
        end
    endtask

    task automatic step(input logic v, input logic rs, input logic r);
        rst      = r;
        restart  = rs;
        in_valid = v;
        in_a     = {$urandom(), $urandom(), $urandom(), $urandom()};
        in_b     = $urandom();
        #1;
        for (int d = 0; d < 2; d++) model(d, v, rs, r);
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            new_frame(d);
            lastvo[d] = 1'b0;
        end
        @(negedge clk);
        // R5: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
        // full-rate feeding: R2 R4 R6 R10
        for (int i = 0; i < 1400; i++) step(1'b1, 1'b0, 1'b0);
        // sparse valid with stalls between rows
        for (int i = 0; i < 1500; i++) step(($urandom() % 10) < 3, 1'b0, 1'b0);
        // R9: restart together with a valid row while ready
        while (!rdy_o[0]) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0, 1'b0);
        // random restarts mid-frame and during drain
        for (int i = 0; i < 2500; i++) step(($urandom() % 2) == 0, ($urandom() % 250) == 0, 1'b0);
        // reset mid-run, then one more full-rate stretch
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 900; i++) step(1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule